// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a downstream FPGA through its passive-serial configuration port. A one-cycle start command begins a session. The block drives the active-low configuration-reset line low for a fixed number of microseconds, releases it, and then waits for the device's status input to read high. Once the status is high, it takes bytes on a valid/ready interface. Each byte is shifted out one bit per pulse of a slow configuration clock, and the data bit is set up before every rising edge.

A one-cycle end command closes the session. The block samples the synchronised status and done inputs and emits a single result pulse. The result code is success, failure, not-complete or timeout. If the status never rises, the wait is abandoned after a parameterised number of microseconds. A strap input marks boards where no device is fitted: it skips the wait and forces success.

The microsecond tick is derived from the system clock frequency. The configuration-clock phase length, the reset pulse width, the timeout and the bit order are all parameters.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_rst_n_o is 1, cfg_clk_o and cfg_data_o are 0, and busy_o, byte_ready_o and res_valid_o are 0.
- R2: A start_i pulse drives cfg_rst_n_o low for exactly RST_US × (CLK_HZ/1e6) system cycles, starting the cycle after start_i. cfg_clk_o and cfg_data_o stay low during this time, and busy_o rises together with the pulse.
- R3: After the pulse, cfg_rst_n_o returns to 1 and stays 1 until the next start_i.
- R4: While cfg_status_i reads 0 after the pulse, byte_ready_o stays 0 and offered bytes cause no clock pulse. byte_ready_o rises within three cycles of cfg_status_i going high.
- R5: Every accepted byte gives exactly 8 pulses on cfg_clk_o. Each high phase lasts at least PHASE_CYC cycles, cfg_data_o is stable at each rising edge, and the clock rests low between bits and bytes.
- R6: With LSB_FIRST=0, bit 7 goes out first. With LSB_FIRST=1, bit 0 goes out first.
- R7: end_i during a transfer gives a one-cycle res_valid_o, with busy_o already 0 in that cycle. res_code_o is 0 (OK) when status and done are both 1, 1 (FAIL) when status is 0, and 2 (NOT_DONE) when status is 1 and done is 0.
- R8: With no_dev_i=1, the status wait is skipped and the end result is always code 0.
- R9: If the status stays 0 for TIMEOUT_US × (CLK_HZ/1e6) cycles after the reset release, res_valid_o pulses with code 3 (TIMEOUT) and busy_o drops.
- R10: Whenever start_i or end_i is 1, byte_ready_o is 0, so a byte offered in the same cycle is not taken. end_i in the middle of a byte stops the clock at once, and start_i restarts the reset pulse.
- R11: Outside a transfer, and while a byte is still shifting, byte_ready_o is 0 and offered bytes cause no clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration session |
| end_i | input | 1 | Close the session and report the result |
| no_dev_i | input | 1 | Strap: no device fitted |
| byte_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_ready_o | output | 1 | Block takes byte_i this cycle |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 1 | Configuration data bit |
| cfg_rst_n_o | output | 1 | Active-low configuration reset |
| cfg_status_i | input | 1 | Device status, high means healthy |
| cfg_done_i | input | 1 | Device configuration done |
| busy_o | output | 1 | Session in progress |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_code_o | output | 2 | 0 OK, 1 FAIL, 2 NOT_DONE, 3 TIMEOUT |

## Verification
Two things can fall in the same cycle: a byte offered on the data interface, and a start or end command. The bench raises byte_valid_i in the cycle where it also raises end_i, and again in a cycle where it raises start_i. It then checks that byte_ready_o was low in that cycle and that no further clock pulses follow. For the end case it checks that the result pulse arrives. For the start case it checks that the reset line drops again. A further case issues end_i while a byte is half shifted out, and the bench checks that the clock is parked low at once.

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PHASE_CYC  = 2,
  parameter int RST_US     = 40,
  parameter int TIMEOUT_US = 20,
  parameter bit LSB_FIRST  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       end_i,
  input  logic       no_dev_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic       cfg_clk_o,
  output logic       cfg_data_o,
  output logic       cfg_rst_n_o,
  input  logic       cfg_status_i,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       res_valid_o,
  output logic [1:0] res_code_o
);

  localparam int TICK   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int US_MAX = (RST_US > TIMEOUT_US) ? RST_US : TIMEOUT_US;
  localparam int PRE_W  = $clog2(TICK + 1);
  localparam int US_W   = $clog2(US_MAX + 1);
  localparam int DIV_W  = $clog2(PHASE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT, S_XFER} st_t;
  localparam logic [1:0] C_OK = 2'd0, C_FAIL = 2'd1, C_NDONE = 2'd2, C_TMO = 2'd3;

  st_t              st;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic [DIV_W-1:0] dcnt;
  logic [7:0]       sh;
  logic [3:0]       bits;
  logic             hi;
  logic [1:0]       stat_s, done_s;

  wire us_tick  = (pre == PRE_W'(TICK - 1));
  wire accept   = byte_valid_i && byte_ready_o;
  wire [7:0] sh_nx = LSB_FIRST ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
  wire first_b  = LSB_FIRST ? byte_i[0] : byte_i[7];
  wire next_b   = LSB_FIRST ? sh_nx[0] : sh_nx[7];

  assign byte_ready_o = (st == S_XFER) && (bits == 4'd0) && !start_i && !end_i;
  assign busy_o       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pre         <= '0;
      us          <= '0;
      dcnt        <= '0;
      sh          <= '0;
      bits        <= '0;
      hi          <= 1'b0;
      stat_s      <= '0;
      done_s      <= '0;
      cfg_clk_o   <= 1'b0;
      cfg_data_o  <= 1'b0;
      cfg_rst_n_o <= 1'b1;
      res_valid_o <= 1'b0;
      res_code_o  <= C_OK;
    end else begin
      res_valid_o <= 1'b0;
      stat_s      <= {stat_s[0], cfg_status_i};
      done_s      <= {done_s[0], cfg_done_i};
      if (start_i) begin
        st          <= S_PULSE;
        pre         <= '0;
        us          <= '0;
        bits        <= '0;
        hi          <= 1'b0;
        cfg_clk_o   <= 1'b0;
        cfg_data_o  <= 1'b0;
        cfg_rst_n_o <= 1'b0;
      end else begin
        case (st)
          S_PULSE: begin
            if (us_tick) begin
              pre <= '0;
              if (us == US_W'(RST_US - 1)) begin
                st          <= S_WAIT;
                us          <= '0;
                cfg_rst_n_o <= 1'b1;
              end else begin
                us <= us + 1'b1;
              end
            end else begin
              pre <= pre + 1'b1;
            end
          end
          S_WAIT: begin
            if (no_dev_i || stat_s[1]) begin
              st <= S_XFER;
            end else if (us_tick) begin
              pre <= '0;
              if (us == US_W'(TIMEOUT_US - 1)) begin
                st          <= S_IDLE;
                res_valid_o <= 1'b1;
                res_code_o  <= C_TMO;
              end else begin
                us <= us + 1'b1;
              end
            end else begin
              pre <= pre + 1'b1;
            end
          end
          S_XFER: begin
            if (end_i) begin
              st          <= S_IDLE;
              bits        <= '0;
              hi          <= 1'b0;
              cfg_clk_o   <= 1'b0;
              res_valid_o <= 1'b1;
              res_code_o  <= no_dev_i   ? C_OK :
                             !stat_s[1] ? C_FAIL :
                             done_s[1]  ? C_OK : C_NDONE;
            end else if (accept) begin
              sh         <= byte_i;
              cfg_data_o <= first_b;
              cfg_clk_o  <= 1'b0;
              hi         <= 1'b0;
              dcnt       <= '0;
              bits       <= 4'd8;
            end else if (bits != 4'd0) begin
              if (dcnt == DIV_W'(PHASE_CYC - 1)) begin
                dcnt <= '0;
                if (!hi) begin
                  cfg_clk_o <= 1'b1;
                  hi        <= 1'b1;
                end else begin
                  cfg_clk_o  <= 1'b0;
                  hi         <= 1'b0;
                  bits       <= bits - 1'b1;
                  sh         <= sh_nx;
                  cfg_data_o <= next_b;
                end
              end else begin
                dcnt <= dcnt + 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11
  ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> busy_o);

  // R5
  clk_rests_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cfg_clk_o);

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk_o) |-> $stable(cfg_data_o));

  // R7
  result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R7
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !busy_o);

  // R2
  pulse_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rst_n_o) |-> $past(start_i));

  // R3
  rst_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n_o |-> (busy_o && !cfg_clk_o));

endmodule

// File: tb/ps_cfg_master_tb.sv
`timescale 1ns/1ps
module ps_cfg_master_tb_top;

  localparam int TICK = 50;
  localparam int RST_CYC = 40 * TICK;
  localparam int TMO_CYC = 20 * TICK;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, end_i = 0, no_dev_i = 0, byte_valid_i = 0;
  logic [7:0] byte_i = 0;
  logic cfg_status_i = 0, cfg_done_i = 0;
  logic byte_ready_o, cfg_clk_o, cfg_data_o, cfg_rst_n_o, busy_o, res_valid_o;
  logic [1:0] res_code_o;
  logic rdy_l, clk_l, dat_l, rstn_l, busy_l, rv_l;
  logic [1:0] code_l;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ps_cfg_master dut_i (.clk, .rst_n, .start_i, .end_i, .no_dev_i, .byte_i, .byte_valid_i,
    .byte_ready_o, .cfg_clk_o, .cfg_data_o, .cfg_rst_n_o, .cfg_status_i, .cfg_done_i,
    .busy_o, .res_valid_o, .res_code_o);

  ps_cfg_master #(.LSB_FIRST(1'b1)) dut_lsb_i (.clk, .rst_n, .start_i, .end_i, .no_dev_i,
    .byte_i, .byte_valid_i, .byte_ready_o(rdy_l), .cfg_clk_o(clk_l), .cfg_data_o(dat_l),
    .cfg_rst_n_o(rstn_l), .cfg_status_i, .cfg_done_i, .busy_o(busy_l),
    .res_valid_o(rv_l), .res_code_o(code_l));

  int pulses = 0;
  logic [7:0] cap_m = 0, cap_l = 0;
  int hi_run = 0, min_hi = 1000;
  always @(posedge cfg_clk_o) begin pulses++; cap_m = {cap_m[6:0], cfg_data_o}; end
  always @(posedge clk_l) cap_l = {dat_l, cap_l[7:1]};
  always @(negedge clk) begin
    if (cfg_clk_o) hi_run++;
    else begin if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run; hi_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic start_session(input bit stat, output int width);
    cfg_status_i = stat;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    width = 0;
    while (!cfg_rst_n_o && width < RST_CYC + 10) begin width++; @(negedge clk); end
  endtask

  task automatic send_byte(input logic [7:0] b);
    int guard = 0;
    while (!byte_ready_o && guard < 100) begin guard++; @(negedge clk); end
    byte_i = b; byte_valid_i = 1;
    @(negedge clk) byte_valid_i = 0;
    guard = 0;
    while (!byte_ready_o && guard < 200) begin guard++; @(negedge clk); end
  endtask

  task automatic finish_session(output logic [1:0] code, output bit busy_at, output bit rv_l_ok);
    int guard = 0;
    @(negedge clk) end_i = 1;
    @(negedge clk) end_i = 0;
    while (!res_valid_o && guard < 10) begin guard++; @(negedge clk); end
    code = res_code_o; busy_at = busy_o; rv_l_ok = rv_l;
    @(negedge clk);
  endtask

  // {byte, stat at end, done at end, no_dev, expected code}
  localparam logic [12:0] VEC [5] = '{
    {8'hA5, 1'b1, 1'b1, 1'b0, 2'd0},
    {8'h3C, 1'b0, 1'b1, 1'b0, 2'd1},
    {8'h81, 1'b1, 1'b0, 1'b0, 2'd2},
    {8'h00, 1'b0, 1'b0, 1'b1, 2'd0},
    {8'h6E, 1'b0, 1'b0, 1'b0, 2'd1}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int w, p0;
    logic [1:0] code;
    bit bz, rvl;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rst_n_o && !cfg_clk_o && !cfg_data_o && !busy_o && !byte_ready_o && !res_valid_o,
        "R1", {cfg_rst_n_o, cfg_clk_o, cfg_data_o, busy_o, byte_ready_o, res_valid_o}, 6'b100000);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rst_n_o && !busy_o, "R1", busy_o, 0);

    // R11 byte offered while idle
    p0 = pulses; byte_i = 8'hFF; byte_valid_i = 1;
    @(negedge clk);
    chk(!byte_ready_o, "R11", byte_ready_o, 0);
    repeat (20) @(negedge clk);
    byte_valid_i = 0;
    chk(pulses == p0, "R11", pulses - p0, 0);

    foreach (VEC[k]) begin
      no_dev_i = VEC[k][2];
      start_session(no_dev_i ? VEC[k][4] : 1'b1, w);
      chk(w == RST_CYC, "R2", w, RST_CYC);
      chk(busy_o, "R2", busy_o, 1);
      p0 = pulses; min_hi = 1000;
      b = VEC[k][12:5];
      send_byte(b);
      chk(cap_m == b, "R6", cap_m, b);
      chk(cap_l == b, "R6", cap_l, b);
      send_byte(~b);
      chk(cap_m == ~b, "R6", cap_m, ~b);
      chk(pulses - p0 == 16, "R5", pulses - p0, 16);
      chk(min_hi >= 2, "R5", min_hi, 2);
      chk(!cfg_clk_o, "R5", cfg_clk_o, 0);
      cfg_status_i = VEC[k][4]; cfg_done_i = VEC[k][3];
      repeat (3) @(negedge clk);
      chk(cfg_rst_n_o, "R3", cfg_rst_n_o, 1);
      finish_session(code, bz, rvl);
      chk(code == VEC[k][1:0], no_dev_i ? "R8" : "R7", code, VEC[k][1:0]);
      chk(!bz && rvl, "R7", bz, 0);
      chk(!res_valid_o, "R7", res_valid_o, 0);
    end
    no_dev_i = 0;

    // R4 status wait, then R9 timeout
    start_session(1'b0, w);
    p0 = pulses; byte_i = 8'h55; byte_valid_i = 1;
    repeat (10) @(negedge clk);
    chk(!byte_ready_o && pulses == p0, "R4", byte_ready_o, 0);
    byte_valid_i = 0;
    cfg_status_i = 1;
    repeat (3) @(negedge clk);
    chk(byte_ready_o, "R4", byte_ready_o, 1);
    finish_session(code, bz, rvl);

    cfg_status_i = 0;
    start_session(1'b0, w);
    w = 0;
    while (!res_valid_o && w < TMO_CYC + 10) begin w++; @(negedge clk); end
    chk(w == TMO_CYC, "R9", w, TMO_CYC);
    chk(res_code_o == 2'd3 && !busy_o, "R9", res_code_o, 3);

    // R10 end together with a byte offer
    start_session(1'b1, w);
    repeat (3) @(negedge clk);
    p0 = pulses;
    byte_i = 8'hC3; byte_valid_i = 1; end_i = 1;
    #1 chk(!byte_ready_o, "R10", byte_ready_o, 0);
    @(negedge clk) byte_valid_i = 0; end_i = 0;
    repeat (20) @(negedge clk);
    chk(pulses == p0 && !busy_o, "R10", pulses - p0, 0);

    // R10 start together with a byte offer
    start_session(1'b1, w);
    repeat (3) @(negedge clk);
    byte_i = 8'h99; byte_valid_i = 1; start_i = 1;
    #1 chk(!byte_ready_o, "R10", byte_ready_o, 0);
    @(negedge clk) byte_valid_i = 0; start_i = 0;
    chk(!cfg_rst_n_o && !cfg_clk_o, "R10", cfg_rst_n_o, 0);
    repeat (RST_CYC + 5) @(negedge clk);

    // R10 end in the middle of a byte
    p0 = pulses;
    byte_i = 8'hF0; byte_valid_i = 1;
    @(negedge clk) byte_valid_i = 0;
    repeat (9) @(negedge clk);
    end_i = 1;
    @(negedge clk) end_i = 0;
    chk(!cfg_clk_o && !busy_o, "R10", cfg_clk_o, 0);
    repeat (20) @(negedge clk);
    chk(pulses - p0 < 8, "R10", pulses - p0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule